// File: doc/BRIEF.md
# Variable-Section Interleaved Modular Multiplier

The block computes `result = X * Y mod M` for an odd modulus `M` and an operand width set by a parameter. A one-cycle `start` loads the three operands (the caller guarantees `Y < M`). At load time the multiplier `X` is rewritten as a signed-digit string in which every digit is -1, 0 or +1 and no two neighbouring digits are both nonzero. That string has one more digit than `X` has bits.

The string is consumed from its top digit downwards, one section per clock. A section is a run of zero digits that ends in a single nonzero digit. The accumulator is multiplied by `2^k` through an unrolled chain of modular doublers, where `k` is the section length. Then `Y` is added or subtracted with one modular correction. A long run of zeros therefore costs one cycle rather than one cycle per digit. The run time follows the count of nonzero digits, not the operand width.

A run of zeros longer than the doubling chain is retired as shift-only steps. When the string is used up, `done` pulses for one cycle and the result stays on `result` until the next load.

Top module: `vlmm_mulmod`

## Requirements
- R1: When `done` is high, `result` equals X·Y mod M for the X, Y, M sampled with the accepted `start`, given M odd and Y < M.
- R2: After reset `busy`, `done` and `result` are 0. `done` is high for exactly one cycle per accepted `start`, and `busy` is low in that cycle.
- R3: A `start` seen while `busy` is high is ignored. The running product, its operands and its result are not disturbed, and no extra `done` follows.
- R4: X = 0 completes normally with a result of 0.
- R5: Let D be the signed-digit form of X. Its digits d_i are in {-1,0,+1}, with X = Σ d_i·2^i, i = 0..WIDTH, and no two adjacent nonzero digits. Let r = WIDTH+1 be the count of unscanned digits. One step is taken per clock while r > 0. If the highest nonzero digit below position r sits at h with r−h ≤ KMAX, the step retires digits r−1..h and sets r = h. Otherwise it retires min(KMAX, r) digits. `done` rises after the last step, so the number of clock edges from the accepted `start` edge (exclusive) to the edge that raises `done` equals the number of steps.
- R6: After every step the accumulator is below M.
- R7: `result` holds its value after `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load operands and begin; ignored while busy |
| xIn | input | WIDTH | Multiplier X |
| yIn | input | WIDTH | Multiplicand Y, below M |
| mIn | input | WIDTH | Odd modulus M |
| busy | output | 1 | Product in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | WIDTH | X·Y mod M, valid from done onward |

## Verification
The hardest situation to reach is a zero run longer than the doubling chain that lies directly in front of a nonzero digit. In that case a shift-only step must be followed by a step that completes the section. The case also needs a minus digit whose subtraction underflows and must be corrected by adding M. Alternating and sparse bit patterns in X produce long runs and isolated negative digits. Random Y close to M and Y = M−1 drive both the add and the subtract corrections to their limits. For every vector, the step count is predicted from an independently computed digit string.

// File: rtl/vlmm_pkg.sv
package vlmm_pkg;
  // strobes from sequencer to arithmetic datapath
  typedef struct packed {
    logic       load;   // capture operands, clear accumulator
    logic       step;   // retire one section
    logic       addY;   // section ends in +1
    logic       subY;   // section ends in -1
    logic [7:0] shift;  // section length k, 1..KMAX
  } vlmm_ctl_t;
endpackage

// File: rtl/vlmm_datapath.sv
module vlmm_datapath
  import vlmm_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int KMAX  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  vlmm_ctl_t        ctl,
  input  logic [WIDTH-1:0] yIn,
  input  logic [WIDTH-1:0] mIn,
  output logic [WIDTH-1:0] result
);
  localparam int EW = WIDTH + 1;

  logic [WIDTH-1:0] accQ, yQ, modQ;
  logic [WIDTH-1:0] dbl [0:KMAX];
  logic [WIDTH-1:0] shifted, accNext;
  logic [EW-1:0]    sumW, difW, modW;

  assign modW   = {1'b0, modQ};
  assign dbl[0] = accQ;

  // unrolled modular doubling chain, each stage output stays below M
  for (genvar g = 0; g < KMAX; g++) begin : g_dbl
    logic [EW-1:0] twice;
    always_comb begin
      twice = {dbl[g], 1'b0};
      if (twice >= modW) twice = twice - modW;
      dbl[g+1] = twice[WIDTH-1:0];
    end
  end

  always_comb begin
    shifted = accQ;
    for (int i = 1; i <= KMAX; i++)
      if (ctl.shift == 8'(i)) shifted = dbl[i];
  end

  always_comb begin
    sumW = {1'b0, shifted} + {1'b0, yQ};
    if (sumW >= modW) sumW = sumW - modW;
    difW = {1'b0, shifted} - {1'b0, yQ};
    if (difW[WIDTH]) difW = difW + modW;
    if (ctl.addY)      accNext = sumW[WIDTH-1:0];
    else if (ctl.subY) accNext = difW[WIDTH-1:0];
    else               accNext = shifted;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
      yQ   <= '0;
      modQ <= '0;
    end else if (ctl.load) begin
      accQ <= '0;
      yQ   <= yIn;
      modQ <= mIn;
    end else if (ctl.step) begin
      accQ <= accNext;
    end
  end

  assign result = accQ;

  // R6
  acc_below_mod_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> accQ < modQ);
  // R3
  operands_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> $stable(modQ) && $stable(yQ));
endmodule

// File: rtl/vlmm_control.sv
module vlmm_control
  import vlmm_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int KMAX  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] xIn,
  output vlmm_ctl_t        ctl,
  output logic             busy,
  output logic             done
);
  localparam int ND   = WIDTH + 1;
  localparam int POSW = $clog2(WIDTH + 2);

  logic            busyQ, doneQ;
  logic [POSW-1:0] posQ, posNext, hiPos, gap, shiftAmt;
  logic [ND-1:0]   nzQ, negQ, nzLoad, negLoad, remMask;
  logic [ND:0]     xExt, x3, flip, negRaw;
  logic            found;

  // signed-digit recoding: compare X with 3X
  always_comb begin
    xExt    = {2'b00, xIn};
    x3      = xExt + {xExt[ND-1:0], 1'b0};
    flip    = x3 ^ xExt;
    negRaw  = xExt & flip;
    nzLoad  = flip[ND:1];
    negLoad = negRaw[ND:1];
  end

  // next nonzero digit below the scan point
  always_comb begin
    found = 1'b0;
    hiPos = '0;
    for (int i = 0; i < ND; i++) begin
      remMask[i] = nzQ[i] && (POSW'(i) < posQ);
      if (remMask[i]) begin
        found = 1'b1;
        hiPos = POSW'(i);
      end
    end
  end

  always_comb begin
    gap = posQ - hiPos;
    ctl = '0;
    ctl.load = start && !busyQ;
    ctl.step = busyQ;
    if (found && gap <= POSW'(KMAX)) begin
      shiftAmt = gap;
      posNext  = hiPos;
      ctl.addY = busyQ && !negQ[hiPos];
      ctl.subY = busyQ && negQ[hiPos];
    end else begin
      shiftAmt = (posQ < POSW'(KMAX)) ? posQ : POSW'(KMAX);
      posNext  = posQ - shiftAmt;
    end
    ctl.shift = 8'(shiftAmt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      posQ  <= '0;
      nzQ   <= '0;
      negQ  <= '0;
    end else if (ctl.load) begin
      busyQ <= 1'b1;
      doneQ <= 1'b0;
      posQ  <= POSW'(ND);
      nzQ   <= nzLoad;
      negQ  <= negLoad;
    end else if (busyQ) begin
      posQ  <= posNext;
      busyQ <= (posNext != '0);
      doneQ <= (posNext == '0);
    end else begin
      doneQ <= 1'b0;
    end
  end

  assign busy = busyQ;
  assign done = doneQ;

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !busyQ);
  // R5
  shift_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (ctl.shift >= 8'd1) && (ctl.shift <= 8'(KMAX)));
  // R3
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && start) |=> posQ < $past(posQ));
endmodule

// File: rtl/vlmm_mulmod.sv
module vlmm_mulmod
  import vlmm_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int KMAX  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] xIn,
  input  logic [WIDTH-1:0] yIn,
  input  logic [WIDTH-1:0] mIn,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result
);
  vlmm_ctl_t ctl;

  vlmm_control #(.WIDTH(WIDTH), .KMAX(KMAX)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .xIn(xIn),
    .ctl(ctl), .busy(busy), .done(done)
  );

  vlmm_datapath #(.WIDTH(WIDTH), .KMAX(KMAX)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .yIn(yIn), .mIn(mIn), .result(result)
  );
endmodule

// File: tb/vlmm_mulmod_test.sv
`timescale 1ns/1ps
module vlmm_mulmod_test;
  localparam int W  = 64;
  localparam int KM = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] xIn = '0, yIn = '0, mIn = '0;
  logic         busy, done;
  logic [W-1:0] result;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  vlmm_mulmod #(.WIDTH(W), .KMAX(KM)) uut (
    .clk(clk), .rstN(rstN), .start(start), .xIn(xIn), .yIn(yIn), .mIn(mIn),
    .busy(busy), .done(done), .result(result)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] refMod(input logic [W-1:0] x, y, m);
    logic [2*W-1:0] p;
    p = {{W{1'b0}}, x} * {{W{1'b0}}, y};
    return W'(p % {{W{1'b0}}, m});
  endfunction

  // step count per R5, digits from carry-based recoding
  function automatic int refSteps(input logic [W-1:0] x);
    bit nz [0:W];
    int c, b, nb, r, h, s;
    c = 0;
    for (int i = 0; i <= W; i++) begin
      b  = (i < W) ? int'(x[i]) : 0;
      nb = (i + 1 < W) ? int'(x[i+1]) : 0;
      nz[i] = 1'b0;
      if (b + c == 1) begin
        nz[i] = 1'b1;
        c = nb;
      end else if (b + c == 2) begin
        c = 1;
      end else begin
        c = 0;
      end
    end
    r = W + 1;
    s = 0;
    while (r > 0) begin
      h = -1;
      for (int i = 0; i < r; i++) if (nz[i]) h = i;
      if (h >= 0 && r - h <= KM) r = h;
      else r = r - ((r < KM) ? r : KM);
      s++;
    end
    return s;
  endfunction

  task automatic runOne(input logic [W-1:0] x, y, m, input bit interfere);
    logic [W-1:0] expRes;
    int n, expN;
    bit seen;
    expRes = refMod(x, y, m);
    expN   = refSteps(x);
    @(negedge clk);
    xIn = x; yIn = y; mIn = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    seen = 1'b0;
    while (n < 4 * W && !seen) begin
      if (interfere && n == 2) begin
        // R3: start while busy with other operands
        xIn = ~x; yIn = 1; mIn = 3; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      n++;
      if (done) seen = 1'b1;
    end
    check(seen, "R2 done seen", 128'(seen), 1);
    if (x == 0) check(result == 0, "R4 zero multiplier", 128'(result), 0);
    else        check(result == expRes, "R1 product", 128'(result), 128'(expRes));
    check(n == expN, "R5 step count", 128'(n), 128'(expN));
    check(!busy, "R2 busy low with done", 128'(busy), 0);
    @(negedge clk);
    check(!done, "R2 done single cycle", 128'(done), 0);
    repeat (2) @(negedge clk);
    check(result == expRes && !done, "R7 result held / R3 no extra done",
          128'(result), 128'(expRes));
  endtask

  initial begin
    logic [W-1:0] m, y, x;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(!busy && !done && result == 0, "R2 reset state",
          {busy, done, result}, 0);
    rstN = 1'b1;
    @(negedge clk);

    m = 64'hFFFF_FFFF_FFFF_FFC5;
    runOne('0, m - 1, m, 0);                          // R4
    runOne('1, m - 1, m, 0);                          // R1 all ones, Y=M-1
    runOne(64'hAAAA_AAAA_AAAA_AAAA, m - 1, m, 0);     // R1 alternating
    runOne(64'h5555_5555_5555_5555, 64'h1234, m, 0);  // R1 alternating
    runOne(64'h8000_0000_0000_0001, m - 1, m, 0);     // R5 long zero run
    runOne(64'h0000_0000_0000_0100, 5, 7, 0);         // R5 sparse, small M
    runOne(64'hF0F0_0000_0000_7777, 0, 13, 0);        // R1 Y=0
    runOne(64'h1234_5678_9ABC_DEF0, 0, 1, 0);         // R1 M=1
    runOne(64'hDEAD_BEEF_0BAD_F00D, m - 1, m, 1);     // R3 interference

    for (int t = 0; t < 200; t++) begin
      m = {$urandom, $urandom} | 64'h1;
      if (t % 3 == 0) m[W-1] = 1'b1;
      y = {$urandom, $urandom} % m;
      if (t % 5 == 0) y = m - 1;
      x = {$urandom, $urandom};
      if (t % 7 == 0) x = x & {$urandom, $urandom} & {$urandom, $urandom};
      runOne(x, y, m, (t % 4 == 0));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule